// File: doc/BRIEF.md
# Serial Scan Access Controller for Dual-Port Test Memories

This block gives test access to a small bank of dual-port memories through a handful of serial pins. A 112-bit command frame is shifted in one bit per clock while the scan enable is high. The frame names one memory and describes a complete access for each of that memory's two ports: address, data, an active-low port select, an active-low write enable and a byte write mask.

Driving the global active-low strobe for one clock while scan is low runs both port accesses. A later load cycle copies the read words into the data fields of the same frame. That frame is then shifted out on `scan_out`, most significant bit first, while the next frame is shifted in. The memories are behavioural arrays inside the block. Each has 32-bit words. Its depth is set by a parameter, and the low address bits of the 16-bit address field index it.

Top module: `sram_scan_ctrl`

## Requirements
- R1: While `rst_n` is low, the scan chain clears to all zeros, so `scan_out` is 0, and every memory word clears to zero.
- R2: While `scan_en` is high, the chain shifts by one bit per clock. `scan_in` enters at frame bit 0, and `scan_out` always shows frame bit 111, so a bit that enters emerges 112 clocks later.
- R3: Frame bit positions are as follows:
  - Memory select: bits 111:108.
  - Port 0: address 107:92, data 91:60, select 59, write enable 58, byte mask 57:54.
  - Port 1: address 53:38, data 37:6, select 5, write enable 4, byte mask 3:0.
- R4: A clock with `csb_n` low and `scan_en` low runs the access. Each port whose select is 0 and whose write enable is 0 writes every byte whose mask bit is 1. Mask bit 0 covers data bits 7:0 and mask bit 3 covers data bits 31:24.
- R5: In the same access, a port whose select is 0 and whose write enable is 1 reads its word. On the next load, that word replaces the port's data field. All other fields of the frame are kept.
- R6: A port whose select bit is 1 neither reads nor writes, and its data field is not changed by a load.
- R7: A memory select of 5 or above performs no access at all, and a load then leaves the frame unchanged.
- R8: When `scan_en` and `load_en` are both high, the chain shifts and does not load. A low `csb_n` has no effect while `scan_en` is high.
- R9: Only the low MEM_AW address bits (default 4) select the word, so addresses that differ only above those bits reach the same word.
- R10: A read returns the word as it was before the writes of the same access. When both ports write the same word in one access, port 1's bytes win.
- R11: With `scan_en`, `load_en` and the strobe all inactive, the chain holds its value. Read results stay captured until the next access, so a repeated load captures the same data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan and memory clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scan_en | input | 1 | Shift the chain one bit per clock |
| load_en | input | 1 | Capture read results into the chain |
| csb_n | input | 1 | Active-low strobe that runs the frame's access |
| scan_in | input | 1 | Serial frame input |
| scan_out | output | 1 | Serial frame output, frame bit 111 |

## Verification
The bound checker watches the chain on every clock and checks four things. Shifting moves every bit up by one place. A load never touches the select, address or control fields. An unselected port's data field survives a load. An idle clock leaves the chain untouched.

The memory effects can only be shown by the bench's scenarios, because the contents are observed through a later read frame. These effects are:
- byte-masked writes;
- reads of old data beside a write in the same access;
- port-1 priority when both ports write one word;
- address aliasing;
- selects of 5 and above that do nothing;
- a strobe that is ignored during a shift.

// File: rtl/sram_scan_ctrl.sv
module sram_scan_ctrl #(
  parameter int NMEM   = 5,
  parameter int SEL_W  = 4,
  parameter int AW     = 16,
  parameter int DW     = 32,
  parameter int MEM_AW = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scan_en,
  input  logic load_en,
  input  logic csb_n,
  input  logic scan_in,
  output logic scan_out
);
  localparam int NB = DW / 8;
  localparam int PW = AW + DW + 2 + NB;
  localparam int FW = SEL_W + 2 * PW;
  localparam int MW = NMEM << MEM_AW;
  localparam int MI = $clog2(MW);

  logic [FW-1:0] chain;
  logic [FW-1:0] cap;
  logic [DW-1:0] mem [MW];
  logic [DW-1:0] rd_q [2];
  logic [1:0]    rd_hit;

  logic [AW-1:0] p_addr [2];
  logic [DW-1:0] p_data [2];
  logic [NB-1:0] p_mask [2];
  logic [MI-1:0] p_idx  [2];
  logic [1:0]    p_rd, p_wr;

  wire [SEL_W-1:0] sel    = chain[FW-1 -: SEL_W];
  wire             sel_ok = sel < SEL_W'(NMEM);
  wire             run    = !csb_n && !scan_en;

  assign scan_out = chain[FW-1];

  for (genvar g = 0; g < 2; g++) begin : g_port
    localparam int B = (1 - g) * PW;
    assign p_mask[g] = chain[B +: NB];
    assign p_data[g] = chain[B+NB+2 +: DW];
    assign p_addr[g] = chain[B+NB+2+DW +: AW];
    assign p_rd[g]   = sel_ok && !chain[B+NB+1] && chain[B+NB];
    assign p_wr[g]   = sel_ok && !chain[B+NB+1] && !chain[B+NB];
    assign p_idx[g]  = MI'({sel, p_addr[g][MEM_AW-1:0]});
  end

  always_comb begin
    cap = chain;
    for (int g = 0; g < 2; g++)
      if (rd_hit[g]) cap[(1-g)*PW+NB+2 +: DW] = rd_q[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain  <= '0;
      rd_hit <= '0;
      for (int g = 0; g < 2; g++) rd_q[g] <= '0;
      for (int i = 0; i < MW; i++) mem[i] <= '0;
    end else begin
      if (scan_en)      chain <= {chain[FW-2:0], scan_in};
      else if (load_en) chain <= cap;
      if (run) begin
        for (int g = 0; g < 2; g++) begin
          rd_hit[g] <= p_rd[g];
          if (p_rd[g]) rd_q[g] <= mem[p_idx[g]];
        end
        for (int g = 0; g < 2; g++)
          if (p_wr[g])
            for (int b = 0; b < NB; b++)
              if (p_mask[g][b]) mem[p_idx[g]][8*b +: 8] <= p_data[g][8*b +: 8];
      end
    end
  end
endmodule

// File: rtl/sram_scan_ctrl_chk.sv
module sram_scan_ctrl_chk #(
  parameter int FW = 112,
  parameter int PW = 54,
  parameter int NB = 4,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scan_en,
  input logic          load_en,
  input logic          scan_in,
  input logic [FW-1:0] chain
);
  a_r1_reset_clear: assert property (@(posedge clk) !rst_n |=> chain == '0);

  a_r2_shift: assert property (@(posedge clk) disable iff (!rst_n)
    scan_en |=> chain == {$past(chain[FW-2:0]), $past(scan_in)});

  a_r5_load_keeps_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && !scan_en) |=>
      chain[FW-1:PW+NB+2+DW] == $past(chain[FW-1:PW+NB+2+DW]) &&
      chain[PW+NB+1:NB+2+DW]  == $past(chain[PW+NB+1:NB+2+DW]) &&
      chain[NB+1:0]          == $past(chain[NB+1:0]));

  a_r6_idle_port_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && !scan_en && chain[PW+NB+1]) |=>
      chain[PW+NB+2 +: DW] == $past(chain[PW+NB+2 +: DW]));

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_en && !load_en) |=> $stable(chain));
endmodule

bind sram_scan_ctrl sram_scan_ctrl_chk #(.FW(FW), .PW(PW), .NB(NB), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .load_en(load_en),
  .scan_in(scan_in), .chain(chain)
);

// File: tb/sram_scan_ctrl_tb.sv
module sram_scan_ctrl_tb_top;
  logic clk = 0, rst_n = 0, scan_en = 0, load_en = 0, csb_n = 1, scan_in = 0;
  logic scan_out;
  int vectors = 0, fails = 0;
  string cur_req = "R1";

  bit q[$];
  logic [31:0] mm [int];
  logic [31:0] mr [2];
  bit mh [2];

  always #10 clk = !clk;

  sram_scan_ctrl dut_i (.clk(clk), .rst_n(rst_n), .scan_en(scan_en), .load_en(load_en),
                        .csb_n(csb_n), .scan_in(scan_in), .scan_out(scan_out));

  function automatic logic [111:0] qframe();
    logic [111:0] f;
    for (int i = 0; i < 112; i++) f[111-i] = q[i];
    return f;
  endfunction

  function automatic logic [111:0] mk(logic [3:0] s,
      logic [15:0] a0, logic [31:0] d0, bit c0, bit w0, logic [3:0] m0,
      logic [15:0] a1, logic [31:0] d1, bit c1, bit w1, logic [3:0] m1);
    return {s, a0, d0, c0, w0, m0, a1, d1, c1, w1, m1};
  endfunction

  task automatic model(bit sc, bit ld, bit cs, bit din);
    logic [111:0] f, nf;
    bit nh [2];
    logic [31:0] nr [2];
    f = qframe();
    nf = f;
    nh = mh; nr = mr;
    if (sc) nf = {f[110:0], din};
    else if (ld) begin
      if (mh[0]) nf[91:60] = mr[0];
      if (mh[1]) nf[37:6]  = mr[1];
    end
    if (!cs && !sc) begin
      int s = f[111:108];
      for (int p = 0; p < 2; p++) begin
        int b = p ? 0 : 54;
        int key = s * 16 + f[b+38 +: 4];
        nh[p] = (s < 5) && !f[b+5] && f[b+4];
        if (nh[p]) nr[p] = mm.exists(key) ? mm[key] : 32'h0;
      end
      for (int p = 0; p < 2; p++) begin
        int b = p ? 0 : 54;
        int key = s * 16 + f[b+38 +: 4];
        logic [31:0] w;
        if ((s < 5) && !f[b+5] && !f[b+4]) begin
          w = mm.exists(key) ? mm[key] : 32'h0;
          for (int k = 0; k < 4; k++) if (f[b+k]) w[8*k +: 8] = f[b+6+8*k +: 8];
          mm[key] = w;
        end
      end
    end
    mh = nh; mr = nr;
    q.delete();
    for (int i = 0; i < 112; i++) q.push_back(nf[111-i]);
  endtask

  task automatic tick(bit sc, bit ld, bit cs, bit din);
    scan_en = sc; load_en = ld; csb_n = cs; scan_in = din;
    @(posedge clk);
    model(sc, ld, cs, din);
    @(negedge clk);
    vectors++;
    if (scan_out !== q[0]) begin
      fails++;
      $display("FAIL %s: scan_out=%b expected %b", cur_req, scan_out, q[0]);
    end
  endtask

  task automatic shift(logic [111:0] f);
    for (int j = 0; j < 112; j++) tick(1, 0, 1, f[111-j]);
  endtask

  task automatic txn(logic [111:0] f);
    shift(f);
    tick(0, 0, 0, 0);
    tick(0, 1, 1, 0);
  endtask

  function automatic logic [111:0] rd2(logic [3:0] s, logic [15:0] a0, logic [15:0] a1);
    return mk(s, a0, 0, 0, 1, 0, a1, 0, 0, 1, 0);
  endfunction

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 112; i++) q.push_back(0);
    mh = '{0, 0}; mr = '{0, 0};
    @(negedge clk); @(negedge clk);
    cur_req = "R1";
    vectors++;
    if (scan_out !== 1'b0) begin fails++; $display("FAIL R1: scan_out=%b expected 0", scan_out); end
    rst_n = 1;
    tick(0, 0, 1, 0);
    txn(rd2(0, 3, 7));

    cur_req = "R4/R5 per memory";
    for (int s = 0; s < 5; s++) begin
      txn(mk(4'(s), 1, 32'(s*100+1), 0, 0, 4'hf, 0, 0, 1, 1, 0));
      txn(mk(4'(s), 0, 0, 1, 1, 0, 2, 32'(s*100+2), 0, 0, 4'hf));
      cur_req = "R3/R5 read back";
      txn(rd2(4'(s), 1, 2));
      cur_req = "R4/R5 per memory";
    end

    cur_req = "R4 byte mask";
    txn(mk(1, 5, 32'hffffffff, 0, 0, 4'hf, 0, 0, 1, 1, 0));
    txn(mk(1, 5, 32'h0, 0, 0, 4'b0101, 0, 0, 1, 1, 0));
    txn(rd2(1, 5, 5));

    cur_req = "R6 idle port";
    txn(mk(2, 1, 0, 0, 1, 0, 1, 32'hdeadbeef, 1, 1, 4'hf));
    txn(mk(2, 1, 0, 1, 0, 4'hf, 1, 32'h0bad0bad, 1, 0, 4'hf));
    txn(rd2(2, 1, 1));

    cur_req = "R7 select out of range";
    txn(mk(5, 1, 32'h11111111, 0, 0, 4'hf, 2, 32'h2222, 0, 1, 0));
    txn(mk(15, 1, 32'h33333333, 0, 0, 4'hf, 2, 32'h4444, 0, 1, 0));
    txn(rd2(0, 1, 2));

    cur_req = "R8 priority";
    shift(rd2(3, 1, 2));
    tick(0, 0, 0, 0);
    tick(1, 1, 1, 1);
    tick(1, 1, 0, 0);
    shift(mk(3, 1, 32'h55555555, 0, 0, 4'hf, 0, 0, 1, 1, 0));
    for (int j = 0; j < 3; j++) tick(1, 0, 0, 0);
    txn(rd2(3, 1, 1));

    cur_req = "R9 alias";
    txn(mk(4, 16'h0013, 32'hcafef00d, 0, 0, 4'hf, 0, 0, 1, 1, 0));
    txn(rd2(4, 16'h0003, 16'hff03));

    cur_req = "R10 ordering";
    txn(mk(0, 9, 32'haaaaaaaa, 0, 0, 4'hf, 9, 32'hbbbbbbbb, 0, 0, 4'hf));
    txn(mk(0, 9, 32'h12345678, 0, 0, 4'hf, 9, 0, 0, 1, 0));
    txn(rd2(0, 9, 9));

    cur_req = "R11 hold";
    for (int j = 0; j < 5; j++) tick(0, 0, 1, 0);
    tick(0, 1, 1, 0);
    tick(0, 1, 1, 0);
    shift(rd2(0, 0, 0));
    shift(rd2(0, 0, 0));

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule